// File: doc/BRIEF.md
# Hierarchical Mailbox Write Event Tracker

This block watches the write traffic of a host-accessible memory that is split into equal partitions, one per context. The low word locations of every partition act as mailboxes. When the host writes one of them, the tracker records the event in a per-context mailbox vector and in a top-level vector that has one bit per context. It also raises a single global event line.

A polling processor reads the top-level vector to find which contexts need service. It then reads the mailbox vector of each such context. When it has handled some mailboxes, it issues a clear command that names one context and a mask of mailbox bits. The command can drop several bits in one operation. A context's top-level bit falls by itself once its last mailbox bit is cleared. A mailbox write that coincides with a clear of the same bit is never lost.

Top module: `mbox_event_tracker`

## Requirements
- R1: A write with `snoop_wr_en` high selects context `snoop_addr[16:12]` and word index `snoop_addr[11:2]`; `snoop_addr[1:0]` is ignored. If the word index is below 24, the write sets bit <word index> of that context's mailbox vector on the next clock edge.
- R2: A write whose word index is 24 or higher changes no mailbox vector and no top-level bit.
- R3: `mbox_event` is high from the clock edge that records a mailbox write, and it stays high while any top-level bit is set. It is low when no top-level bit is set.
- R4: Top-level bit c is set exactly when context c's mailbox vector is nonzero.
- R5: With `clr_en` high, every bit that is set in `clr_mask` is cleared in the mailbox vector of context `clr_ctx`, all in one cycle. No other context is affected.
- R6: When a clear leaves a context's mailbox vector all zero, that context's top-level bit is cleared on the same edge.
- R7: If a mailbox write and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: A read presents its selection at a clock edge, and `rd_data` shows the result after that edge. With `rd_sel_ctx` low the result is the 32-bit top-level vector, where bit c is context c. With `rd_sel_ctx` high the result is the mailbox vector of context `rd_ctx` in bits [23:0], and bits [31:24] are zero.
- R9: After synchronous active-low reset, all vectors, `rd_data` and `mbox_event` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoop_wr_en | input | 1 | Snooped write strobe on the shared memory bus |
| snoop_addr | input | 17 | Snooped byte address of the write |
| clr_en | input | 1 | Clear command strobe |
| clr_ctx | input | 5 | Context addressed by the clear command |
| clr_mask | input | 24 | Mailbox bits to clear |
| rd_sel_ctx | input | 1 | 0 selects the top-level vector, 1 selects a context vector |
| rd_ctx | input | 5 | Context whose mailbox vector is read |
| rd_data | output | 32 | Registered read result |
| mbox_event | output | 1 | Global pending-mailbox indication |

## Verification
A snooped write or a clear command takes effect on the rising edge where it is presented, so the vectors and `mbox_event` change one edge after the stimulus. A read result appears after the edge that samples the selection, which is also one edge later. The bench drives every input on the falling edge and holds it through exactly one rising edge. It then samples on the next falling edge, so each result is checked in the first half-cycle in which it is due. Vector contents are observed only through the read port. This covers the writes that are ignored and the clears that must leave other contexts untouched.

// File: rtl/mbox_trk_pkg.sv
// Shared sizes and types for the mailbox write event tracker.
// Assumes word addressing: byte offset in [1:0], then word index, then context.
package mbox_trk_pkg;
    localparam int NUM_CTX  = 32;
    localparam int NUM_MBOX = 24;
    localparam int CTX_W    = $clog2(NUM_CTX);
    localparam int WORD_W   = 10;
    localparam int ADDR_W   = 2 + WORD_W + CTX_W;
    localparam int MBOX_W   = $clog2(NUM_MBOX);
    localparam int RD_W     = NUM_CTX;

    typedef logic [NUM_MBOX-1:0] mbox_vec_t;
endpackage

// File: rtl/mbox_addr_decode.sv
// Decodes a snooped bus write into (hit, context, mailbox index).
// Assumes the partition layout given by the package; purely combinational.
module mbox_addr_decode
    import mbox_trk_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CTX_W-1:0]  ctx,
    output logic [MBOX_W-1:0] mbox
);
    logic [WORD_W-1:0] word;

    // Split the address into its fields and flag writes to mailbox words.
    always_comb begin
        word = addr[2 +: WORD_W];
        ctx  = addr[2 + WORD_W +: CTX_W];
        hit  = wr_en && (word < WORD_W'(NUM_MBOX));
        mbox = word[MBOX_W-1:0];
    end
endmodule

// File: rtl/mbox_ctx_bank.sv
// Holds one context's mailbox vector and its top-level pending bit.
// Assumes set and clear masks are already qualified for this context;
// a set always wins over a clear of the same bit.
module mbox_ctx_bank
    import mbox_trk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mbox_vec_t set_vec,
    input  mbox_vec_t clr_vec,
    output mbox_vec_t vec,
    output logic      pend
);
    mbox_vec_t vec_nxt;

    // Next mailbox vector: clear first, then apply sets so sets win.
    always_comb vec_nxt = (vec & ~clr_vec) | set_vec;

    // Register the mailbox vector and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec  <= '0;
            pend <= 1'b0;
        end else begin
            vec <= vec_nxt;
            if (set_vec != '0)
                pend <= 1'b1;
            else if (clr_vec != '0)
                pend <= |vec_nxt;
        end
    end

    AST_PEND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (vec != '0)); // R4
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((vec & $past(set_vec)) == $past(set_vec))); // R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((vec & $past(clr_vec & ~set_vec)) == '0)); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> $stable(vec)); // R2
endmodule

// File: rtl/mbox_read_mux.sv
// Registered read port: top-level vector or one context's mailbox vector.
// Assumes the read width is at least the mailbox count; upper bits zero-filled.
module mbox_read_mux
    import mbox_trk_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_ctx,
    input  logic [CTX_W-1:0]          ctx,
    input  logic [NUM_CTX-1:0]        top_vec,
    input  mbox_vec_t [NUM_CTX-1:0]   ctx_vecs,
    output logic [RD_W-1:0]           data
);
    // Capture the selected vector on each clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (sel_ctx)
            data <= RD_W'(ctx_vecs[ctx]);
        else
            data <= RD_W'(top_vec);
    end

    AST_RD_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctx |=> (data[RD_W-1:NUM_MBOX] == '0)); // R8
endmodule

// File: rtl/mbox_event_tracker.sv
// Top level: snoops memory writes, keeps a two-level context/mailbox summary,
// takes per-context masked clears and offers a registered read port.
// Assumes one snooped write and one clear command at most per cycle.
module mbox_event_tracker
    import mbox_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snoop_wr_en,
    input  logic [16:0]       snoop_addr,
    input  logic              clr_en,
    input  logic [4:0]        clr_ctx,
    input  logic [23:0]       clr_mask,
    input  logic              rd_sel_ctx,
    input  logic [4:0]        rd_ctx,
    output logic [31:0]       rd_data,
    output logic              mbox_event
);
    logic                     wr_hit;
    logic [CTX_W-1:0]         wr_ctx;
    logic [MBOX_W-1:0]        wr_mbox;
    mbox_vec_t                wr_onehot;
    mbox_vec_t [NUM_CTX-1:0]  ctx_vecs;
    logic [NUM_CTX-1:0]       top_vec;

    mbox_addr_decode u_dec (
        .wr_en (snoop_wr_en),
        .addr  (snoop_addr),
        .hit   (wr_hit),
        .ctx   (wr_ctx),
        .mbox  (wr_mbox)
    );

    // One-hot mailbox bit for the decoded write.
    always_comb wr_onehot = mbox_vec_t'(1) << wr_mbox;

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        mbox_vec_t set_c;
        mbox_vec_t clr_c;

        // Qualify the write and the clear for this context.
        always_comb begin
            set_c = (wr_hit && wr_ctx == CTX_W'(c)) ? wr_onehot : '0;
            clr_c = (clr_en && clr_ctx == CTX_W'(c)) ? clr_mask : '0;
        end

        mbox_ctx_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_c),
            .clr_vec (clr_c),
            .vec     (ctx_vecs[c]),
            .pend    (top_vec[c])
        );
    end

    // Global event is the OR of all top-level bits.
    always_comb mbox_event = |top_vec;

    mbox_read_mux u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_ctx  (rd_sel_ctx),
        .ctx      (rd_ctx),
        .top_vec  (top_vec),
        .ctx_vecs (ctx_vecs),
        .data     (rd_data)
    );

    AST_WR_RAISES_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> mbox_event); // R3
    AST_WR_SETS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> top_vec[$past(wr_ctx)]); // R1
endmodule

// File: tb/mbox_event_tracker_tb.sv
module mbox_event_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snoop_wr_en = 1'b0;
    logic [16:0] snoop_addr = '0;
    logic        clr_en = 1'b0;
    logic [4:0]  clr_ctx = '0;
    logic [23:0] clr_mask = '0;
    logic        rd_sel_ctx = 1'b0;
    logic [4:0]  rd_ctx = '0;
    logic [31:0] rd_data;
    logic        mbox_event;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mbox_event_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .snoop_wr_en(snoop_wr_en), .snoop_addr(snoop_addr),
        .clr_en(clr_en), .clr_ctx(clr_ctx), .clr_mask(clr_mask),
        .rd_sel_ctx(rd_sel_ctx), .rd_ctx(rd_ctx), .rd_data(rd_data), .mbox_event(mbox_event)
    );

    function automatic logic [16:0] addr_of(input int ctx, input int word, input int byteoff);
        return 17'((ctx << 12) | (word << 2) | byteoff);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at negedge, hold through one posedge.
    task automatic step(input bit we, input logic [16:0] a, input bit ce,
                        input int cc, input logic [23:0] cm);
        @(negedge clk);
        snoop_wr_en = we; snoop_addr = a;
        clr_en = ce; clr_ctx = 5'(cc); clr_mask = cm;
        @(negedge clk);
        snoop_wr_en = 1'b0; clr_en = 1'b0;
    endtask

    task automatic wr(input int ctx, input int word);
        step(1'b1, addr_of(ctx, word, 1), 1'b0, 0, '0);
    endtask

    task automatic clr(input int ctx, input logic [23:0] m);
        step(1'b0, '0, 1'b1, ctx, m);
    endtask

    task automatic rd_top(output logic [31:0] d);
        @(negedge clk); rd_sel_ctx = 1'b0;
        @(negedge clk); d = rd_data;
    endtask

    task automatic rd_vec(input int ctx, output logic [31:0] d);
        @(negedge clk); rd_sel_ctx = 1'b1; rd_ctx = 5'(ctx);
        @(negedge clk); d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R9 event", 32'(mbox_event), 0);
        rd_top(d);      check("R9 top", d, 0);
        rd_vec(0, d);   check("R9 ctx0", d, 0);
        rd_vec(31, d);  check("R9 ctx31", d, 0);
    endtask

    task automatic t_set;
        logic [31:0] d;
        wr(3, 5);
        check("R3 event after write", 32'(mbox_event), 1);
        rd_vec(3, d);   check("R1 ctx3 vector", d, 32'h20);
        rd_top(d);      check("R4 top", d, 32'h8);
        check("R8 upper zero", 32'(d[31:24] == 0 ? 0 : 1), 0);
    endtask

    task automatic t_ignore;
        logic [31:0] d;
        wr(3, 24);
        wr(3, 100);
        wr(7, 30);
        rd_vec(3, d);   check("R2 ctx3 unchanged", d, 32'h20);
        rd_vec(7, d);   check("R2 ctx7 empty", d, 0);
        rd_top(d);      check("R2 top unchanged", d, 32'h8);
    endtask

    task automatic t_multi_clear;
        logic [31:0] d;
        wr(3, 0); wr(3, 1); wr(3, 23); wr(9, 2);
        rd_vec(3, d);   check("R1 ctx3 several", d, 32'h800023);
        clr(3, 24'h000023);
        rd_vec(3, d);   check("R5 ctx3 masked clear", d, 32'h800000);
        rd_vec(9, d);   check("R5 ctx9 untouched", d, 32'h4);
        rd_top(d);      check("R4 top both", d, 32'h208);
    endtask

    task automatic t_auto_drop;
        logic [31:0] d;
        clr(3, 24'h800000);
        rd_top(d);      check("R6 ctx3 top bit drops", d, 32'h200);
        check("R3 event held", 32'(mbox_event), 1);
        clr(9, 24'hFFFFFF);
        check("R3 event low", 32'(mbox_event), 0);
        rd_top(d);      check("R6 top empty", d, 0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        wr(31, 10);
        step(1'b1, addr_of(31, 4, 3), 1'b1, 31, 24'hFFFFFF);
        rd_vec(31, d);  check("R7 set wins", d, 32'h10);
        rd_top(d);      check("R7 top kept", d, 32'h80000000);
        check("R3 event kept", 32'(mbox_event), 1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_ignore();
        t_multi_clear();
        t_auto_drop();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule